// File: doc/BRIEF.md
# Pipelined Bus Output-Register Slave

This block is a single-clock AHB-Lite slave holding one small output register, typically wired to LEDs or other static control lines. The master writes the register and reads it back. In the address phase the slave captures the select, address, direction and transfer type. In the data phase that follows, it either takes the byte from the low lane of the write data bus, or it presents the register value, zero-extended, on the read data bus.

A build-time parameter adds 0 to 3 wait states to every data phase. One word offset is write-protected: a write there gets the two-cycle ERROR response and does not change the register. Reads of that offset complete normally. The next address phase overlaps the current data phase, so transfers go back to back. With no wait states, one transfer completes per cycle. SEQ transfers are handled exactly like NONSEQ singles.

Top module: `outreg_ahb_slave`

## Requirements
- R1: After reset the output register is zero, `hreadyout` is 1 and `hresp` is 0 (OKAY).
- R2: A transfer is taken only in a cycle where `hsel`=1, `hready`=1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00), BUSY (2'b01) and unselected cycles change nothing. The cycle after such a cycle shows `hreadyout`=1 and `hresp`=0.
- R3: A write to a non-protected word offset with `haddr[1:0]`=0 loads `hwdata[7:0]` into the register at the clock edge that completes its data phase.
- R4: In the completing cycle of a read data phase, `hrdata` equals the register zero-extended to the bus width. In every other cycle `hrdata` is 0.
- R5: Every data phase begins with exactly `WAIT_STATES` cycles of `hreadyout`=0 and `hresp`=0. An OKAY data phase then completes with one cycle of `hreadyout`=1 and `hresp`=0.
- R6: A write to word offset `PROT_WORD` (default 1, i.e. byte address 4) leaves the register unchanged. After the wait cycles it answers with `hresp`=1 and `hreadyout`=0, then with `hresp`=1 and `hreadyout`=1.
- R7: The next address phase is held until the current data phase completes, and it is accepted at that edge. A run of transfers therefore takes 1 + the sum of the data-phase lengths in cycles: `WAIT_STATES`+1 for OKAY, `WAIT_STATES`+2 for ERROR, and 1 for each unaccepted cycle.
- R8: A write whose `haddr[1:0]` is not 0 does not cover byte lane 0. It completes OKAY and leaves the register unchanged.
- R9: A read of the protected offset completes OKAY and returns the register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock, rising edge |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select from the address decoder |
| haddr | input | ADDR_W | Byte address of the address phase |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready; high when the previous data phase completes |
| hreadyout | output | 1 | This slave's ready |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| hrdata | output | DATA_W | Read data |
| outBits | output | REG_W | Output register contents |

## Verification
The embedded properties assume that `hready` equals this slave's own `hreadyout` whenever the slave owns a data phase. They also assume that the master keeps its address phase unchanged while the slave stalls. Without these, the ERROR and wait-length properties would be judging a transfer the slave never saw complete. The bench enforces both conditions: each instance has `hready` looped straight back from its `hreadyout`, and the stimulus presents one address phase and holds it until it sees `hreadyout` high before moving on. Every second transfer uses SEQ instead of NONSEQ to show the two types are handled the same.

// File: rtl/outreg_pkg.sv
package outreg_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam int MAX_WAIT = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_LAST,
    PH_ERR1,
    PH_ERR2
  } phase_e;

  typedef struct packed {
    logic commitWrite;
    logic driveRead;
  } dp_strobe_t;
endpackage

// File: rtl/outreg_ctrl.sv
module outreg_ctrl
  import outreg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WAIT_STATES = 0,
  parameter int PROT_WORD   = 1
) (
  input  logic              clk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic              hready,
  output logic              hreadyout,
  output logic              hresp,
  output dp_strobe_t        strobe
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WAIT_STATES > 0 ? WAIT_STATES - 1 : 0);
  localparam logic [ADDR_W-3:0] PROT_IDX = (ADDR_W-2)'(PROT_WORD);

  phase_e           phase, nextPhase, startPhase;
  logic [CNT_W-1:0] waitCnt;
  logic             dpWrite, dpErr, dpLane0;
  logic             canAccept, accept, newErr;

  assign canAccept = (phase == PH_IDLE) || (phase == PH_LAST) || (phase == PH_ERR2);
  assign accept    = hsel && hready && ((htrans == TR_NONSEQ) || (htrans == TR_SEQ));
  assign newErr    = hwrite && (haddr[ADDR_W-1:2] == PROT_IDX);

  always_comb begin
    if (WAIT_STATES > 0) startPhase = PH_WAIT;
    else if (newErr)     startPhase = PH_ERR1;
    else                 startPhase = PH_LAST;
  end

  always_comb begin
    nextPhase = phase;
    unique case (phase)
      PH_IDLE, PH_LAST, PH_ERR2: nextPhase = accept ? startPhase : PH_IDLE;
      PH_WAIT: if (waitCnt == '0) nextPhase = dpErr ? PH_ERR1 : PH_LAST;
      PH_ERR1: nextPhase = PH_ERR2;
      default: nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge hresetn) begin
    if (!hresetn) begin
      phase   <= PH_IDLE;
      waitCnt <= '0;
      dpWrite <= 1'b0;
      dpErr   <= 1'b0;
      dpLane0 <= 1'b0;
    end else begin
      phase <= nextPhase;
      if (canAccept && accept) begin
        waitCnt <= WAIT_LOAD;
        dpWrite <= hwrite;
        dpErr   <= newErr;
        dpLane0 <= (haddr[1:0] == 2'b00);
      end else if (phase == PH_WAIT && waitCnt != '0) begin
        waitCnt <= waitCnt - 1'b1;
      end
    end
  end

  assign hreadyout          = !((phase == PH_WAIT) || (phase == PH_ERR1));
  assign hresp              = (phase == PH_ERR1) || (phase == PH_ERR2);
  assign strobe.commitWrite = (phase == PH_LAST) && dpWrite && dpLane0;
  assign strobe.driveRead   = (phase == PH_LAST) && !dpWrite;

  // Run length of stalled OKAY cycles, used to bound the wait window
  logic [2:0] lowRun;
  always_ff @(posedge clk or negedge hresetn) begin
    if (!hresetn)                  lowRun <= '0;
    else if (hreadyout || hresp)   lowRun <= '0;
    else if (lowRun != 3'd7)       lowRun <= lowRun + 1'b1;
  end

  // R5: never more stalled cycles than configured
  p_wait_bound_r5: assert property (@(posedge clk) disable iff (!hresetn)
    (!hreadyout && !hresp) |-> (int'(lowRun) < WAIT_STATES));

  // R6: first ERROR cycle is always followed by the second
  p_err_second_r6: assert property (@(posedge clk) disable iff (!hresetn)
    (hresp && !hreadyout) |=> (hresp && hreadyout));

  // R6: ERROR only for a captured protected write
  p_err_cause_r6: assert property (@(posedge clk) disable iff (!hresetn)
    (hresp && !hreadyout) |-> (dpWrite && dpErr));

  // R2: no accepted transfer means an idle OKAY cycle next
  p_idle_ready_r2: assert property (@(posedge clk) disable iff (!hresetn)
    (hreadyout && !(hsel && hready && htrans[1])) |=> (hreadyout && !hresp));

  // R3: a register update only happens in an OKAY completing cycle
  p_commit_okay_r3: assert property (@(posedge clk) disable iff (!hresetn)
    strobe.commitWrite |-> (hreadyout && !hresp));
endmodule

// File: rtl/outreg_dp.sv
module outreg_dp
  import outreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              hresetn,
  input  dp_strobe_t        strobe,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] hrdata,
  output logic [REG_W-1:0]  outBits
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PAD_W = DATA_W - REG_W;

  logic [REG_W-1:0] outReg;
  logic             unusedHiLanes;

  assign unusedHiLanes = ^hwdata[DATA_W-1:REG_W];

  always_ff @(posedge clk or negedge hresetn) begin
    if (!hresetn)                outReg <= '0;
    else if (strobe.commitWrite) outReg <= hwdata[REG_W-1:0];
  end

  assign hrdata  = strobe.driveRead ? {{PAD_W{1'b0}}, outReg} : '0;
  assign outBits = outReg;

  // R3: the register moves only on a commit strobe from the control
  p_reg_hold_r3: assert property (@(posedge clk) disable iff (!hresetn)
    !strobe.commitWrite |=> $stable(outReg));
endmodule

// File: rtl/outreg_ahb_slave.sv
module outreg_ahb_slave
  import outreg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int REG_W       = 8,
  parameter int WAIT_STATES = 0,
  parameter int PROT_WORD   = 1
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  output logic              hreadyout,
  output logic              hresp,
  output logic [DATA_W-1:0] hrdata,
  output logic [REG_W-1:0]  outBits
);
  timeunit 1ns;
  timeprecision 1ps;

  dp_strobe_t strobe;

  outreg_ctrl #(
    .ADDR_W(ADDR_W), .WAIT_STATES(WAIT_STATES), .PROT_WORD(PROT_WORD)
  ) u_ctrl (
    .clk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hready(hready), .hreadyout(hreadyout), .hresp(hresp),
    .strobe(strobe)
  );

  outreg_dp #(
    .DATA_W(DATA_W), .REG_W(REG_W)
  ) u_dp (
    .clk(hclk), .hresetn(hresetn), .strobe(strobe), .hwdata(hwdata),
    .hrdata(hrdata), .outBits(outBits)
  );
endmodule

// File: tb/outreg_ahb_slave_test.sv
module outreg_ahb_slave_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int REG_W  = 8;
  localparam int PROT   = 1;
  localparam int MAXOPS = 1024;

  logic clk = 1'b0;
  logic hresetn = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]        hselV;
  logic [1:0]        hwriteV;
  logic [1:0]        htransV [2];
  logic [ADDR_W-1:0] haddrV  [2];
  logic [DATA_W-1:0] hwdataV [2];
  logic              readyV  [2];
  logic              respV   [2];
  logic [DATA_W-1:0] rdataV  [2];
  logic [REG_W-1:0]  bitsV   [2];

  for (genvar k = 0; k < 2; k++) begin : g_cfg
    outreg_ahb_slave #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
      .WAIT_STATES(k == 0 ? 0 : 3), .PROT_WORD(PROT)
    ) uut (
      .hclk(clk), .hresetn(hresetn), .hsel(hselV[k]), .haddr(haddrV[k]),
      .htrans(htransV[k]), .hwrite(hwriteV[k]), .hwdata(hwdataV[k]),
      .hready(readyV[k]), .hreadyout(readyV[k]), .hresp(respV[k]),
      .hrdata(rdataV[k]), .outBits(bitsV[k])
    );
  end

  int checks = 0;
  int failures = 0;

  // kinds: 0 idle, 1 busy, 2 unselected, 3 nonseq, 4 seq
  int                nOps = 0;
  int                opKind [MAXOPS];
  logic              opW    [MAXOPS];
  logic [ADDR_W-1:0] opAddr [MAXOPS];
  logic [DATA_W-1:0] opData [MAXOPS];

  task automatic addOp(input int kind, input logic w, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d);
    opKind[nOps] = kind; opW[nOps] = w; opAddr[nOps] = a; opData[nOps] = d;
    nOps++;
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit isErr(input int i);
    return opKind[i] >= 3 && opW[i] && (int'(opAddr[i][ADDR_W-1:2]) == PROT);
  endfunction

  task automatic runCfg(input int k);
    int ws = (k == 0) ? 0 : 3;
    int ai = 0;
    int di = -1;
    int cyc = 0;
    int cycles = 0;
    int expCycles = 1;
    logic [REG_W-1:0] model = '0;
    bit err, expR, expP, actReady;
    logic [DATA_W-1:0] expD;
    string tag;
    for (int i = 0; i < nOps; i++)
      expCycles += (opKind[i] >= 3) ? (ws + 1 + (isErr(i) ? 1 : 0)) : 1;
    while (ai < nOps || di >= 0) begin
      if (ai < nOps) begin
        hselV[k]   = (opKind[ai] != 2);
        hwriteV[k] = opW[ai];
        haddrV[k]  = opAddr[ai];
        case (opKind[ai])
          0: htransV[k] = 2'b00;
          1: htransV[k] = 2'b01;
          4: htransV[k] = 2'b11;
          default: htransV[k] = 2'b10;
        endcase
      end else begin
        hselV[k] = 1'b0; htransV[k] = 2'b00; hwriteV[k] = 1'b0;
      end
      hwdataV[k] = (di >= 0) ? opData[di] : 32'hDEAD_BE5A;
      #2;
      err = (di >= 0) && isErr(di);
      if (di < 0)          begin expR = 1; expP = 0; tag = "R2"; end
      else if (cyc < ws)   begin expR = 0; expP = 0; tag = "R5"; end
      else if (!err)       begin expR = 1; expP = 0; tag = "R5"; end
      else if (cyc == ws)  begin expR = 0; expP = 1; tag = "R6"; end
      else                 begin expR = 1; expP = 1; tag = "R6"; end
      expD = (di >= 0 && !opW[di] && expR) ? {{(DATA_W-REG_W){1'b0}}, model} : '0;
      chk(readyV[k] == expR, tag, "hreadyout", {31'b0, readyV[k]}, {31'b0, expR});
      chk(respV[k] == expP, tag, "hresp", {31'b0, respV[k]}, {31'b0, expP});
      chk(rdataV[k] == expD,
          (di >= 0 && int'(opAddr[di][ADDR_W-1:2]) == PROT) ? "R9" : "R4",
          "hrdata", rdataV[k], expD);
      chk(bitsV[k] == model, "R3", "outBits", {24'b0, bitsV[k]}, {24'b0, model});
      actReady = readyV[k];
      @(posedge clk); #1;
      cycles++;
      if (actReady) begin
        if (di >= 0 && opW[di] && !err && opAddr[di][1:0] == 2'b00)
          model = opData[di][REG_W-1:0];
        if (ai < nOps) begin
          di = (opKind[ai] >= 3) ? ai : -1;
          ai++;
        end else di = -1;
        cyc = 0;
      end else cyc++;
      if (cycles > 20000) break;
    end
    hselV[k] = 1'b0; htransV[k] = 2'b00;
    chk(cycles == expCycles, "R7", "run length", cycles, expCycles);
    // R6/R8/R2 leave the register as the model says, checked after the run
    chk(bitsV[k] == model, "R8", "final outBits", {24'b0, bitsV[k]}, {24'b0, model});
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      hselV[k] = 1'b0; hwriteV[k] = 1'b0; htransV[k] = 2'b00;
      haddrV[k] = '0; hwdataV[k] = '0;
    end
    // reset-value read, basic write / SEQ read back to back
    addOp(3, 0, 16'h0000, 0);
    addOp(3, 1, 16'h0000, 32'h1111_113C);
    addOp(4, 0, 16'h0000, 0);
    // R2: idle, busy and unselected writes are ignored
    addOp(0, 1, 16'h0000, 0);
    addOp(1, 1, 16'h0000, 0);
    addOp(2, 1, 16'h0000, 0);
    addOp(3, 0, 16'h0008, 0);
    // R8: lane 0 not covered
    addOp(3, 1, 16'h0001, 32'h0000_0077);
    addOp(4, 1, 16'h0002, 32'h0000_0077);
    addOp(3, 0, 16'h0000, 0);
    // R6 then R9: protected write, protected read
    addOp(3, 1, 16'h0004, 32'h0000_0099);
    addOp(3, 0, 16'h0004, 0);
    // sweep every byte value over word offsets 0..3 with a read after each
    for (int v = 0; v < 256; v++) begin
      addOp((v % 2 == 0) ? 3 : 4, 1, ADDR_W'((v % 4) * 4), {8'hA5, 8'(v ^ 8'hFF), 8'h3C, 8'(v)});
      addOp((v % 2 == 0) ? 4 : 3, 0, ADDR_W'(((v + 1) % 8) * 4), 0);
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    for (int k = 0; k < 2; k++) begin
      chk(readyV[k] == 1'b1, "R1", "hreadyout", {31'b0, readyV[k]}, 1);
      chk(respV[k] == 1'b0, "R1", "hresp", {31'b0, respV[k]}, 0);
      chk(bitsV[k] == '0, "R1", "outBits", {24'b0, bitsV[k]}, 0);
      chk(rdataV[k] == '0, "R4", "hrdata idle", rdataV[k], 0);
    end
    hresetn = 1'b1;
    @(posedge clk); #1;
    for (int k = 0; k < 2; k++) runCfg(k);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule